// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block turns one request for a single NAND bus transfer into correctly timed pin activity. The four transfer kinds are command, address, data write and data read. The requester presents an operation code, a data word and a flag that marks operations that put the flash into a busy period. It holds the request until a one-cycle acknowledge returns. For a read, the captured word is valid alongside that acknowledge.

All strobe timing comes from a single packed timing register. Write and read strobes are described by the clock edge positions at which the strobe rises and ends. Extra delays cover three cases:
- bus turnaround after a read;
- chip-enable lead time before the first read strobe after the chip is newly selected;
- a settling delay before the ready/busy pin is first sampled.

The timing register can only be written after a key has been written to a separate lock register. A configuration input selects an 8-bit or 16-bit data bus.

Top module: `nand_strobe_timer`

## Requirements
- R1: The timing word packs these fields:
  - write strobe low position in bits 3:0;
  - write cycle end position in bits 7:4;
  - read strobe low position in bits 11:8;
  - read cycle end position in bits 15:12;
  - read turnaround count in bits 18:16;
  - busy settling count in bits 23:19;
  - chip-enable lead count in bits 25:24.

  The value after reset is 0x01225252.
- R2: For op code 2 (write), op code 0 (command) and op code 1 (address), we_no is low for (write low position + 1) cycles and is then high for (end − low) cycles before the acknowledge. re_no stays high throughout.
- R3: For op code 3 (read), re_no is low for (read low position + 1) cycles, and we_no stays high. dq_i is captured on the last low cycle and appears on rdata_o with the acknowledge.
- R4: After the read strobe high phase, read turnaround cycles pass before the acknowledge, so the next transfer cannot drive the bus earlier.
- R5: When busy_op_i is set, busy settling cycles pass after the strobe cycle. The block then polls the synchronized ready/busy level, and the acknowledge comes only after that level is high. After rb_i rises, the acknowledge is seen on the third clock edge.
- R6: The chip-enable lead count of cycles is inserted before the read strobe only when ce_no was high before the read started. A read that follows an acknowledged transfer back to back gets no lead.
- R7: The register write select works as follows:
  - With cfg_sel_i = 0, a write of exactly 0x0000A25E arms one timing write. Any other value written there disarms it.
  - With cfg_sel_i = 1, a write updates the timing word only when armed. Every such write disarms.
- R8: cle_o is high only for op code 0 and ale_o only for op code 1. Both are stable over the whole strobe low and high phases. ack_o is high for exactly one cycle per transfer.
- R9: When bus16_i is 0, bits 15:8 of dq_o and of rdata_o are zero. When it is 1, all 16 bits pass.
- R10: ready_o follows rb_i through two flip-flops. It is low while the busy settling count runs.
- R11: When the end position is not greater than the low position, the strobe high phase lasts one cycle.
- R12: The following hold on the bus pins:
  - ce_no is low whenever a strobe is low.
  - ce_no returns high after an acknowledge when no request follows.
  - dq_oe_o is high only during write-type strobe cycles and never while re_no is low.
  - After reset, all strobes are high and dq_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = lock register, 1 = timing register |
| cfg_wdata_i | input | 32 | Register write data |
| bus16_i | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| req_i | input | 1 | Transfer request, held until acknowledge |
| op_i | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| busy_op_i | input | 1 | Transfer starts a flash busy period |
| wdata_i | input | 16 | Word for command, address or write |
| ack_o | output | 1 | One-cycle transfer completion |
| rdata_o | output | 16 | Captured read word |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| dq_o | output | 16 | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | 16 | Data bus input value |
| rb_i | input | 1 | Flash ready/busy pin, high = ready |
| ready_o | output | 1 | Synchronized ready level |

## Verification
Transfers are run under three timing words:
- a default with ordinary spacing;
- a word whose end positions sit at or below the low positions, which exercises the one-cycle high-phase floor with no turnaround and no settling;
- a word with a zero read low position and long turnaround.

Each transfer's strobe length and total cycle count are measured, so an error in the low count, the high count, the turnaround or the settling term gives a different total. Back-to-back reads and reads after an idle gap tell the chip-enable lead apart from plain read timing. The read data source changes value on every low cycle, so only capture on the last low cycle gives the expected word. Lock sequences check key, wrong key and repeated timing writes, each judged by the timing of the next transfer. A held-low ready/busy pin is released at a known cycle, which locates the acknowledge exactly.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } nand_op_e;

  // field order mirrors the register bit layout, msb first
  typedef struct packed {
    logic [1:0] cea;
    logic [4:0] bdly;
    logic [2:0] ta;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } nand_tim_t;

  localparam int unsigned TIM_W    = $bits(nand_tim_t);
  localparam logic [15:0] LOCK_KEY = 16'hA25E;

endpackage

// File: rtl/nand_tim_cfg.sv
module nand_tim_cfg
  import nand_tim_pkg::*;
#(
  parameter logic [31:0] TIM_RST = 32'h0122_5252
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        sel_i,
  input  logic [31:0] wdata_i,
  output nand_tim_t   tim_o
);

  logic      unlock_q;
  nand_tim_t tim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      tim_q    <= nand_tim_t'(TIM_RST[TIM_W-1:0]);
    end else if (we_i) begin
      if (!sel_i) begin
        unlock_q <= (wdata_i == {16'h0000, LOCK_KEY});
      end else begin
        if (unlock_q) tim_q <= nand_tim_t'(wdata_i[TIM_W-1:0]);
        unlock_q <= 1'b0;
      end
    end
  end

  assign tim_o = tim_q;

  AST_UNLOCK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |=> !unlock_q);  // R7
  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i && !unlock_q) |=> $stable(tim_q));  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tim_q));  // R7

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], rb_i};
  end

  assign rb_o = sync_q[STAGES-1];

endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
  import nand_tim_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  nand_tim_t     tim_i,
  input  logic          bus16_i,
  input  logic          req_i,
  input  nand_op_e      op_i,
  input  logic          busy_op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  input  logic          rb_sync_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          re_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          wait_busy_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_CEA, S_LOW, S_HIGH, S_TA, S_BWAIT, S_BPOLL, S_DONE
  } st_e;

  localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  nand_op_e         op_q;
  logic [DW-1:0]    dat_q, rdata_q;
  logic             bsy_q, ce_n_q;

  logic             is_rd, start, in_cycle;
  logic [3:0]       lo_cur, hi_cur, lo_new;
  logic [CNT_W-1:0] hi_init;
  st_e              after_st;
  logic [CNT_W-1:0] after_cnt;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic w16);
    return w16 ? d : (d & BYTE_MASK);
  endfunction

  assign is_rd    = (op_q == OP_RD);
  assign start    = (st_q == S_IDLE || st_q == S_DONE) && req_i;
  assign in_cycle = (st_q == S_LOW) || (st_q == S_HIGH);
  assign lo_cur   = is_rd ? tim_i.rd_lo : tim_i.wr_lo;
  assign hi_cur   = is_rd ? tim_i.rd_hi : tim_i.wr_hi;
  assign lo_new   = (op_i == OP_RD) ? tim_i.rd_lo : tim_i.wr_lo;
  // high phase floor of one cycle
  assign hi_init  = (hi_cur > lo_cur) ? CNT_W'(hi_cur - lo_cur - 4'd1) : '0;

  // exit path once the strobe cycle and any turnaround are done
  always_comb begin
    after_st  = S_DONE;
    after_cnt = '0;
    if (bsy_q) begin
      if (tim_i.bdly != '0) begin
        after_st  = S_BWAIT;
        after_cnt = CNT_W'(tim_i.bdly) - CNT_W'(1);
      end else begin
        after_st  = S_BPOLL;
      end
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE, S_DONE: begin
        if (req_i) begin
          if (op_i == OP_RD && ce_n_q && tim_i.cea != '0) begin
            st_d  = S_CEA;
            cnt_d = CNT_W'(tim_i.cea) - CNT_W'(1);
          end else begin
            st_d  = S_LOW;
            cnt_d = CNT_W'(lo_new);
          end
        end else begin
          st_d = S_IDLE;
        end
      end
      S_CEA: begin
        if (cnt_q == '0) begin
          st_d  = S_LOW;
          cnt_d = CNT_W'(lo_cur);
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      S_LOW: begin
        if (cnt_q == '0) begin
          st_d  = S_HIGH;
          cnt_d = hi_init;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      S_HIGH: begin
        if (cnt_q == '0) begin
          if (is_rd && tim_i.ta != '0) begin
            st_d  = S_TA;
            cnt_d = CNT_W'(tim_i.ta) - CNT_W'(1);
          end else begin
            st_d  = after_st;
            cnt_d = after_cnt;
          end
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      S_TA: begin
        if (cnt_q == '0) begin
          st_d  = after_st;
          cnt_d = after_cnt;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      S_BWAIT: begin
        if (cnt_q == '0) st_d = S_BPOLL;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      S_BPOLL: if (rb_sync_i) st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_CMD;
      dat_q   <= '0;
      bsy_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start) begin
        op_q   <= op_i;
        dat_q  <= fit(wdata_i, bus16_i);
        bsy_q  <= busy_op_i;
        ce_n_q <= 1'b0;
      end else if ((st_q == S_IDLE || st_q == S_DONE) && !req_i) begin
        ce_n_q <= 1'b1;
      end
      if (st_q == S_LOW && cnt_q == '0 && is_rd) rdata_q <= fit(dq_i, bus16_i);
    end
  end

  assign ack_o       = (st_q == S_DONE);
  assign rdata_o     = rdata_q;
  assign cle_o       = in_cycle && (op_q == OP_CMD);
  assign ale_o       = in_cycle && (op_q == OP_ADDR);
  assign ce_no       = ce_n_q;
  assign we_no       = !((st_q == S_LOW) && !is_rd);
  assign re_no       = !((st_q == S_LOW) && is_rd);
  assign dq_o        = dat_q;
  assign dq_oe_o     = in_cycle && !is_rd;
  assign wait_busy_o = (st_q == S_BWAIT);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R8
  AST_LATCH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_HIGH) |-> ($stable(cle_o) && $stable(ale_o)));  // R8
  AST_CE_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);  // R12
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o);  // R12
  AST_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_BPOLL && !rb_sync_i) |=> !ack_o);  // R5
  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !req_i) |=> (we_no && re_no));  // R12

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nand_tim_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] TIM_RST     = 32'h0122_5252
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          bus16_i,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic          busy_op_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          re_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i,
  input  logic          rb_i,
  output logic          ready_o
);

  nand_tim_t tim;
  logic      rb_sync, wait_busy;

  nand_tim_cfg #(.TIM_RST(TIM_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .tim_o   (tim)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rb_i   (rb_i),
    .rb_o   (rb_sync)
  );

  nand_cycle_fsm #(.DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tim_i       (tim),
    .bus16_i     (bus16_i),
    .req_i       (req_i),
    .op_i        (nand_op_e'(op_i)),
    .busy_op_i   (busy_op_i),
    .wdata_i     (wdata_i),
    .dq_i        (dq_i),
    .rb_sync_i   (rb_sync),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .cle_o       (cle_o),
    .ale_o       (ale_o),
    .ce_no       (ce_no),
    .we_no       (we_no),
    .re_no       (re_no),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .wait_busy_o (wait_busy)
  );

  assign ready_o = rb_sync && !wait_busy;

  AST_READY_LOW_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_busy |-> !ready_o);  // R10
  AST_ACK_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && busy_op_i && req_i && $past(!ack_o)) |-> $past(rb_sync));  // R5

endmodule

// File: tb/tb_nand_strobe_timer.sv
`timescale 1ns/1ps
module tb_nand_strobe_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wd = '0;
  logic        bus16 = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        busy_op = 1'b0;
  logic [15:0] wd = '0;
  logic        ack_o, cle_o, ale_o, ce_no, we_no, re_no, dq_oe_o, ready_o;
  logic [15:0] rdata_o, dq_o;
  logic [15:0] dq_i = '0;
  logic        rb = 1'b1;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nand_strobe_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wd), .bus16_i(bus16), .req_i(req), .op_i(op),
    .busy_op_i(busy_op), .wdata_i(wd), .ack_o(ack_o), .rdata_o(rdata_o),
    .cle_o(cle_o), .ale_o(ale_o), .ce_no(ce_no), .we_no(we_no), .re_no(re_no),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i), .rb_i(rb), .ready_o(ready_o)
  );

  typedef struct {
    int          lo_we;
    int          lo_re;
    int          tot;
    logic [15:0] rdata;
    logic [15:0] dq;
    logic        cle;
    logic        ale;
    bit          rd;
  } exp_t;

  exp_t        q[$];
  logic [31:0] tim_cur = 32'h0122_5252;
  bit          ce_idle = 1'b1;
  logic [15:0] rbase = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fit(input logic [15:0] v);
    return bus16 ? v : {8'h00, v[7:0]};
  endfunction

  // flash model: data on the bus changes on every read-low cycle
  int rk = 0;
  always @(negedge clk) begin
    if (!re_no) begin
      rk++;
      dq_i <= rbase + 16'(rk);
    end else begin
      rk = 0;
      dq_i <= '0;
    end
  end

  // monitor / scoreboard
  int m_cnt = 0, m_lwe = 0, m_lre = 0;
  bit m_bad_dq = 0, m_bad_ctl = 0;
  always begin
    @(posedge clk); #1;
    if (rst_n && req && q.size() > 0) begin
      m_cnt++;
      if (!we_no) m_lwe++;
      if (!re_no) m_lre++;
      if (!we_no && (!dq_oe_o || dq_o !== q[0].dq)) m_bad_dq = 1;
      if (!re_no && dq_oe_o) m_bad_dq = 1;
      if ((!we_no || !re_no) && (cle_o !== q[0].cle || ale_o !== q[0].ale || ce_no)) m_bad_ctl = 1;
      if (ack_o) begin
        exp_t e;
        e = q.pop_front();
        chk(m_lwe == e.lo_we, "R2 write strobe low length", m_lwe, e.lo_we);
        chk(m_lre == e.lo_re, "R3 read strobe low length", m_lre, e.lo_re);
        if (e.tot >= 0) chk(m_cnt == e.tot, "R2/R4/R6 transfer cycles", m_cnt, e.tot);
        if (e.rd) chk(rdata_o === e.rdata, "R3 R9 read capture", rdata_o, e.rdata);
        chk(!m_bad_dq, "R12 R9 bus drive", m_bad_dq, 0);
        chk(!m_bad_ctl, "R8 latch enables", m_bad_ctl, 0);
        m_cnt = 0; m_lwe = 0; m_lre = 0; m_bad_dq = 0; m_bad_ctl = 0;
      end
    end
  end

  task automatic cfg_wr(input bit sel, input logic [31:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wd = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // called at a negedge
  task automatic xfer(input logic [1:0] o, input logic [15:0] d, input bit bsy,
                      input bit keep, input bit skip_tot);
    exp_t e;
    int lo, hi, t, l4, h4;
    bit rd;
    rd = (o == 2'd3);
    l4 = rd ? int'(tim_cur[11:8])  : int'(tim_cur[3:0]);
    h4 = rd ? int'(tim_cur[15:12]) : int'(tim_cur[7:4]);
    lo = l4 + 1;
    hi = (h4 > l4) ? h4 - l4 : 1;  // R11 floor
    t  = lo + hi + 1;
    if (rd) t += int'(tim_cur[18:16]);
    if (rd && ce_idle) t += int'(tim_cur[25:24]);
    if (bsy) t += int'(tim_cur[23:19]) + 1;
    if (rd) rbase = d;
    e.lo_we = rd ? 0 : lo;
    e.lo_re = rd ? lo : 0;
    e.tot   = skip_tot ? -1 : t;
    e.rdata = fit(d + 16'(lo));
    e.dq    = fit(d);
    e.cle   = (o == 2'd0);
    e.ale   = (o == 2'd1);
    e.rd    = rd;
    q.push_back(e);
    req = 1'b1; op = o; wd = d; busy_op = bsy;
    do begin @(posedge clk); #1; end while (!ack_o);
    @(negedge clk);
    if (!keep) begin
      req = 1'b0;
      @(negedge clk);
      chk(ce_no == 1'b1, "R12 chip enable released when idle", ce_no, 1);
      ce_idle = 1'b1;
    end else begin
      ce_idle = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(we_no && re_no && !ack_o && !dq_oe_o && ce_no, "R12 reset pin state",
        {we_no, re_no, ack_o, dq_oe_o, ce_no}, 5'b11001);
    chk(ready_o == 1'b0, "R10 ready low in reset", ready_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1, "R10 ready after two flops", ready_o, 1);

    // R1 default timing, R2 R3 R8 basic patterns, R6 back to back then idle
    xfer(2'd0, 16'h0090, 0, 1, 0);
    xfer(2'd1, 16'h0012, 0, 1, 0);
    xfer(2'd2, 16'hBEEF, 0, 1, 0);
    xfer(2'd3, 16'h1000, 0, 0, 0);   // R6 no lead: back to back
    xfer(2'd3, 16'h2000, 0, 0, 0);   // R6 lead: fresh chip enable, R4 turnaround
    xfer(2'd0, 16'h0010, 1, 0, 0);   // R5 settling plus poll

    // R7 locked write ignored
    cfg_wr(1'b1, 32'h0300_1300);
    xfer(2'd2, 16'h5A5A, 0, 0, 0);
    // R7 key then write takes effect; R11 floors
    cfg_wr(1'b0, 32'h0000_A25E);
    cfg_wr(1'b1, 32'h0300_1300);
    tim_cur = 32'h0300_1300;
    xfer(2'd2, 16'h1234, 0, 0, 0);   // R11 write high floor
    xfer(2'd3, 16'h4000, 0, 0, 0);   // R11 read high floor, R6 lead of 3
    xfer(2'd1, 16'h0077, 1, 0, 0);   // R5 zero settling
    // R7 wrong key disarms
    cfg_wr(1'b0, 32'h0000_A25E);
    cfg_wr(1'b0, 32'h0000_1234);
    cfg_wr(1'b1, 32'h0015_2041);
    xfer(2'd2, 16'h0F0F, 0, 0, 0);
    // R7 single use of the key
    cfg_wr(1'b0, 32'h0000_A25E);
    cfg_wr(1'b1, 32'h0015_2041);
    cfg_wr(1'b1, 32'h0122_5252);
    tim_cur = 32'h0015_2041;
    xfer(2'd3, 16'h6000, 0, 1, 0);   // R4 turnaround of 5
    xfer(2'd2, 16'h3C3C, 0, 0, 0);
    xfer(2'd0, 16'h0060, 1, 0, 0);   // R5 settling of 2

    // R9 byte bus
    bus16 = 1'b0;
    xfer(2'd2, 16'hABCD, 0, 0, 0);
    xfer(2'd3, 16'h34F0, 0, 0, 0);
    bus16 = 1'b1;

    // R5 R10 ready/busy held low
    rb = 1'b0;
    repeat (4) @(negedge clk);
    chk(ready_o == 1'b0, "R10 ready follows pin low", ready_o, 0);
    fork
      xfer(2'd0, 16'h00D0, 1, 0, 1);
      begin
        repeat (40) @(negedge clk);
        chk(ack_o == 1'b0, "R5 no acknowledge while busy", ack_o, 0);
        rb = 1'b1;
        @(posedge clk); #1;
        chk(ack_o == 1'b0, "R5 ack not after one edge", ack_o, 0);
        @(posedge clk); #1;
        chk(ack_o == 1'b0, "R5 ack not after two edges", ack_o, 0);
        chk(ready_o == 1'b1, "R10 ready two edges after pin", ready_o, 1);
        @(posedge clk); #1;
        chk(ack_o == 1'b1, "R5 ack on third edge", ack_o, 1);
      end
    join

    chk(q.size() == 0, "R8 every transfer acknowledged", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule